// File: doc/BRIEF.md
# Dual-Lane SPI Position Reader

This block is an SPI master for a position sensor that returns two data streams at once, one for the X axis and one for the Y axis. A single-cycle trigger starts one acquisition. The block lowers chip select, produces a fixed number of serial clock periods, and shifts in the two sensor data lines side by side. Each word is assembled most significant bit first. The block then raises chip select and flags completion with a done level, and both words appear on parallel outputs.

The sensor answers through cables and level shifters, so the data edge arrives late. The block does not sample right at the rising serial-clock edge. It samples a set number of system clocks after that edge, which absorbs the round-trip delay. The serial-clock half-period, the sampling delay and the word length are all parameters. The words and the values on the data lines never change how long a frame lasts. Every acquisition takes the same number of system clocks, so software can use the block as a timing reference.

Top module: `dual_spi_pos_reader`

## Requirements
- R1: While chip select is high, the serial clock is low. After the trigger is accepted, the serial clock stays low for HALF_CLKS system clocks. It then toggles every HALF_CLKS clocks and gives exactly FRAME_BITS rising edges, and it ends low.
- R2: Chip select falls on the clock edge that accepts a trigger. It stays low for exactly 2*FRAME_BITS*HALF_CLKS + SAMPLE_DLY system clocks, then rises.
- R3: Both data lines are sampled on the system clock edge that lies SAMPLE_DLY clocks after each rising serial-clock edge. The first sampled bit becomes bit FRAME_BITS-1 of the word and the last becomes bit 0. The X line feeds x_word and the Y line feeds y_word.
- R4: x_word and y_word take the newly assembled words on the edge where done rises. They then hold those values, including through the next acquisition, until done rises again. Both are zero after reset.
- R5: Done rises on the same edge as chip select. It stays high with no trigger, and it falls on the edge that accepts the next trigger.
- R6: A trigger that arrives while chip select is low is ignored. It neither restarts nor lengthens the frame in progress.
- R7: A frame begins only when a trigger is accepted, never because the previous frame has completed. The values on the data lines have no effect on frame length or serial-clock timing.
- R8: While reset is high and after it is released, chip select is high, the serial clock is low, done is low, and both words are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| trig | input | 1 | Acquisition start pulse, taken only while idle |
| miso_x | input | 1 | Serial data from the sensor, X axis |
| miso_y | input | 1 | Serial data from the sensor, Y axis |
| sclk | output | 1 | Serial clock to the sensor, idle low |
| cs_n | output | 1 | Chip select, active low |
| done | output | 1 | Acquisition complete, held until the next trigger |
| x_word | output | FRAME_BITS | Last X word received |
| y_word | output | FRAME_BITS | Last Y word received |

## Verification
The bench models a sensor that changes its data some system clocks after each falling serial-clock edge. The sampling delay decides whether the right bit is caught: sampling right at the rising edge would capture the previous bit. Complementary words on the two lanes (all zeros against all ones, and alternating patterns) show whether the lanes are swapped or mixed. Random words show whether the bit order is wrong. Triggers are also given in several other ways: in the middle of a frame, held high across two frames, right after done, and not at all for a long idle stretch. These separate a correct design from one that restarts, one that stretches the frame, and one that re-arms by itself.

// File: rtl/dual_spi_pos_pkg.sv
package dual_spi_pos_pkg;
   // Number of sensor data lanes, and the index of each one.
   localparam int LANES  = 2;
   localparam int LANE_X = 0;
   localparam int LANE_Y = 1;

   // Counter width for values 0..n-1, at least one bit.
   function automatic int cnt_w(input int n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/dual_spi_clkgen.sv
module dual_spi_clkgen #(
   parameter int HALF_CLKS  = 20,
   parameter int FRAME_BITS = 16
) (
   input  logic clk,
   input  logic rst,
   input  logic start,
   input  logic run,
   output logic sclk,
   output logic rise
);
   import dual_spi_pos_pkg::*;

   localparam int TOGGLES = 2 * FRAME_BITS;
   localparam int HW      = cnt_w(HALF_CLKS);
   localparam int TW      = cnt_w(TOGGLES + 1);

   logic [HW-1:0] half_cnt;
   logic [TW-1:0] tog_cnt;
   logic          more;
   logic          half_end;

   assign more     = (tog_cnt != TW'(TOGGLES));
   assign half_end = (half_cnt == HW'(HALF_CLKS - 1));
   assign rise     = run && more && half_end && !sclk;

   always_ff @(posedge clk) begin
      if (rst || start) begin
         half_cnt <= '0;
         tog_cnt  <= '0;
         sclk     <= 1'b0;
      end else if (run && more) begin
         if (half_end) begin
            half_cnt <= '0;
            sclk     <= ~sclk;
            tog_cnt  <= tog_cnt + 1'b1;
         end else begin
            half_cnt <= half_cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/dual_spi_strobe_delay.sv
module dual_spi_strobe_delay #(
   parameter int DEPTH = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic din,
   output logic dout
);
   generate
      if (DEPTH == 0) begin : g_none
         assign dout = din;
      end else if (DEPTH == 1) begin : g_one
         logic q;
         always_ff @(posedge clk) begin
            if (rst) q <= 1'b0;
            else     q <= din;
         end
         assign dout = q;
      end else begin : g_line
         logic [DEPTH-1:0] line;
         always_ff @(posedge clk) begin
            if (rst) line <= '0;
            else     line <= {line[DEPTH-2:0], din};
         end
         assign dout = line[DEPTH-1];
      end
   endgenerate
endmodule

// File: rtl/dual_spi_lane_shifter.sv
module dual_spi_lane_shifter #(
   parameter int FRAME_BITS = 16,
   parameter int LANES      = 2
) (
   input  logic                                  clk,
   input  logic                                  rst,
   input  logic                                  shift,
   input  logic [LANES-1:0]                      din,
   output logic [LANES-1:0][FRAME_BITS-1:0]      word
);
   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         always_ff @(posedge clk) begin
            if (rst)
               word[g] <= '0;
            else if (shift)
               word[g] <= {word[g][FRAME_BITS-2:0], din[g]};
         end
      end
   endgenerate
endmodule

// File: rtl/dual_spi_pos_reader.sv
module dual_spi_pos_reader #(
   parameter int HALF_CLKS  = 20,
   parameter int SAMPLE_DLY = 4,
   parameter int FRAME_BITS = 16
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  trig,
   input  logic                  miso_x,
   input  logic                  miso_y,
   output logic                  sclk,
   output logic                  cs_n,
   output logic                  done,
   output logic [FRAME_BITS-1:0] x_word,
   output logic [FRAME_BITS-1:0] y_word
);
   import dual_spi_pos_pkg::*;

   localparam int FRAME_CLKS = 2 * FRAME_BITS * HALF_CLKS + SAMPLE_DLY;
   localparam int CW         = cnt_w(FRAME_CLKS);

   if (HALF_CLKS < 1) begin : g_bad_half
      $error("HALF_CLKS must be at least 1");
   end
   if (FRAME_BITS < 2) begin : g_bad_bits
      $error("FRAME_BITS must be at least 2");
   end
   if (SAMPLE_DLY < 0 || SAMPLE_DLY > 64) begin : g_bad_dly
      $error("SAMPLE_DLY must lie in 0..64");
   end

   logic                             busy;
   logic [CW-1:0]                    fcnt;
   logic                             start;
   logic                             last;
   logic                             rise;
   logic                             smp;
   logic [LANES-1:0]                 lane_in;
   logic [LANES-1:0][FRAME_BITS-1:0] lane_word;

   assign start = trig && !busy;
   assign last  = busy && (fcnt == CW'(FRAME_CLKS - 1));
   assign cs_n  = ~busy;

   assign lane_in[LANE_X] = miso_x;
   assign lane_in[LANE_Y] = miso_y;

   dual_spi_clkgen #(
      .HALF_CLKS (HALF_CLKS),
      .FRAME_BITS(FRAME_BITS)
   ) u_clkgen (
      .clk  (clk),
      .rst  (rst),
      .start(start),
      .run  (busy),
      .sclk (sclk),
      .rise (rise)
   );

   dual_spi_strobe_delay #(
      .DEPTH(SAMPLE_DLY)
   ) u_dly (
      .clk (clk),
      .rst (rst),
      .din (rise),
      .dout(smp)
   );

   dual_spi_lane_shifter #(
      .FRAME_BITS(FRAME_BITS),
      .LANES     (LANES)
   ) u_shift (
      .clk  (clk),
      .rst  (rst),
      .shift(smp),
      .din  (lane_in),
      .word (lane_word)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         busy   <= 1'b0;
         fcnt   <= '0;
         done   <= 1'b0;
         x_word <= '0;
         y_word <= '0;
      end else if (start) begin
         busy <= 1'b1;
         fcnt <= '0;
         done <= 1'b0;
      end else if (busy) begin
         if (last) begin
            busy   <= 1'b0;
            done   <= 1'b1;
            x_word <= lane_word[LANE_X];
            y_word <= lane_word[LANE_Y];
         end else begin
            fcnt <= fcnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/dual_spi_pos_reader_chk.sv
module dual_spi_pos_reader_chk #(
   parameter int HALF_CLKS  = 20,
   parameter int SAMPLE_DLY = 4,
   parameter int FRAME_BITS = 16
) (
   input logic                  clk,
   input logic                  rst,
   input logic                  trig,
   input logic                  miso_x,
   input logic                  miso_y,
   input logic                  sclk,
   input logic                  cs_n,
   input logic                  done,
   input logic [FRAME_BITS-1:0] x_word,
   input logic [FRAME_BITS-1:0] y_word
);
   localparam int FRAME_CLKS = 2 * FRAME_BITS * HALF_CLKS + SAMPLE_DLY;

   int   low_cnt;
   int   rise_cnt;
   logic sclk_q;

   always_ff @(posedge clk) begin
      if (rst || cs_n) low_cnt <= 0;
      else             low_cnt <= low_cnt + 1;
   end

   always_ff @(posedge clk) begin
      if (rst) sclk_q <= 1'b0;
      else     sclk_q <= sclk;
      if (rst || cs_n)         rise_cnt <= 0;
      else if (sclk && !sclk_q) rise_cnt <= rise_cnt + 1;
   end

   assert_sclk_quiet_R1: assert property (@(posedge clk) disable iff (rst)
      cs_n |-> !sclk);

   assert_rise_count_R1: assert property (@(posedge clk) disable iff (rst)
      $rose(cs_n) |-> (rise_cnt == FRAME_BITS));

   // R6: a retrigger that restarted the frame would break this count too
   assert_frame_len_R2: assert property (@(posedge clk) disable iff (rst)
      $rose(cs_n) |-> (low_cnt == FRAME_CLKS));

   assert_words_hold_R4: assert property (@(posedge clk) disable iff (rst)
      !$rose(done) |-> ($stable(x_word) && $stable(y_word)));

   assert_done_with_cs_R5: assert property (@(posedge clk) disable iff (rst)
      $rose(done) |-> $rose(cs_n));

   assert_done_hold_R5: assert property (@(posedge clk) disable iff (rst)
      (done && !trig) |=> done);

   assert_start_needs_trig_R7: assert property (@(posedge clk) disable iff (rst)
      $fell(cs_n) |-> $past(trig));
endmodule

bind dual_spi_pos_reader dual_spi_pos_reader_chk #(
   .HALF_CLKS (HALF_CLKS),
   .SAMPLE_DLY(SAMPLE_DLY),
   .FRAME_BITS(FRAME_BITS)
) u_chk (.*);

// File: tb/dual_spi_pos_reader_test.sv
`timescale 1ns/1ps
module dual_spi_pos_reader_test;
   localparam int HALF = 3;
   localparam int DLY  = 4;
   localparam int BITS = 8;
   localparam int PD   = 4;   // sensor data lag after SCLK fall, in clocks
   localparam int LEN  = 2 * BITS * HALF + DLY;

   logic            clk = 1'b0;
   logic            rst = 1'b1;
   logic            trig = 1'b0;
   logic            miso_x = 1'b0;
   logic            miso_y = 1'b0;
   logic            sclk, cs_n, done;
   logic [BITS-1:0] x_word, y_word;

   int total = 0;
   int bad   = 0;
   bit ended = 0;

   // reference model state
   bit              m_busy = 0;
   bit              m_done = 0;
   int              m_j    = 0;
   logic [BITS-1:0] m_x = '0, m_y = '0;
   logic [BITS-1:0] cur_x = '0, cur_y = '0;
   logic [BITS-1:0] pat_x = '0, pat_y = '0;

   always #2 clk = ~clk;

   dual_spi_pos_reader #(
      .HALF_CLKS (HALF),
      .SAMPLE_DLY(DLY),
      .FRAME_BITS(BITS)
   ) uut (
      .clk(clk), .rst(rst), .trig(trig), .miso_x(miso_x), .miso_y(miso_y),
      .sclk(sclk), .cs_n(cs_n), .done(done), .x_word(x_word), .y_word(y_word)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
      end
   endtask

   task automatic compare();
      bit exp_sclk;
      exp_sclk = m_busy && (m_j < 2 * BITS * HALF) && (((m_j / HALF) % 2) == 1);
      chk(sclk == exp_sclk, "R1 sclk", 32'(sclk), 32'(exp_sclk));
      chk(cs_n == !m_busy, "R2 cs_n", 32'(cs_n), 32'(!m_busy));
      chk(done == m_done, "R5 done", 32'(done), 32'(m_done));
      chk(x_word == m_x, "R3/R4 x_word", 32'(x_word), 32'(m_x));
      chk(y_word == m_y, "R3/R4 y_word", 32'(y_word), 32'(m_y));
   endtask

   // one clock: drive at negedge, update model at posedge, compare at next negedge
   task automatic step(input bit t);
      int k;
      trig = t;
      if (t && !m_busy && !rst) begin
         cur_x = pat_x;
         cur_y = pat_y;
      end
      k = (m_busy && m_j >= PD) ? ((m_j - PD) / (2 * HALF) + 1) : 0;
      if (k >= 1 && k <= BITS) begin
         miso_x = cur_x[BITS-k];
         miso_y = cur_y[BITS-k];
      end else begin
         miso_x = 1'($urandom);
         miso_y = 1'($urandom);
      end
      @(posedge clk);
      if (rst) begin
         m_busy = 0; m_done = 0; m_j = 0; m_x = '0; m_y = '0;
      end else if (!m_busy && t) begin
         m_busy = 1; m_j = 0; m_done = 0;
      end else if (m_busy) begin
         if (m_j == LEN - 1) begin
            m_busy = 0; m_done = 1; m_x = cur_x; m_y = cur_y;
         end else begin
            m_j++;
         end
      end
      @(negedge clk);
      compare();
   endtask

   task automatic frame(input logic [BITS-1:0] px, input logic [BITS-1:0] py);
      pat_x = px;
      pat_y = py;
      step(1'b1);
      repeat (LEN + 3) step(1'b0);
   endtask

   initial begin
      @(negedge clk);
      // R8: reset state, with triggers that must be ignored under reset
      step(1'b0); step(1'b1); step(1'b0);
      rst = 1'b0;
      repeat (3) step(1'b0);

      // R3, R7: lane separation, bit order and data independence
      frame(8'h00, 8'hFF);
      frame(8'hFF, 8'h00);
      frame(8'hA5, 8'h5A);
      frame(8'h81, 8'h7E);
      for (int i = 0; i < 5; i++) frame(8'($urandom), 8'($urandom));

      // R6: triggers inside a frame at several points
      pat_x = 8'h3C; pat_y = 8'hC3;
      step(1'b1);
      for (int c = 1; c < LEN + 4; c++)
         step(c == 1 || c == HALF + 1 || c == LEN / 2 || c == LEN - 1);

      // R5, R7: long idle with done held and no restart
      repeat (120) step(1'b0);

      // R4, R5: trigger held high across two frames
      pat_x = 8'h96; pat_y = 8'h69;
      repeat (2 * LEN + 4) step(1'b1);
      step(1'b0);

      // R5: trigger on the first cycle after done
      pat_x = 8'h11; pat_y = 8'hEE;
      step(1'b1);
      while (m_busy) step(1'b0);
      pat_x = 8'h5F; pat_y = 8'hF5;
      step(1'b1);
      repeat (LEN + 5) step(1'b0);

      // R8: reset after activity clears everything
      rst = 1'b1;
      step(1'b0); step(1'b0);
      rst = 1'b0;
      step(1'b0);

      ended = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!ended) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule